// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs Clause 22 management transactions between a host-side register pair and an external Ethernet PHY. Software first polls the finished flag. For a write, it loads a 16-bit data register. It then writes a 16-bit command word that packs a PHY address, a register number and a direction bit. That command write is what starts the frame.

The engine divides the system clock down to MDC and shifts the frame out on the MDIO output. During the turnaround and data bits of a read, it lets go of the line. When the frame ends, the read value is placed in the data register and the finished flag returns to 1.

The MDC ratio is the parameter `MDC_DIV`, an even number of at least 2. Preamble suppression and Clause 45 framing are not supported.

Top module: `mdio_cmd_engine`

## Requirements
- R1: The command word holds the register number in bits 4:0, the PHY address in bits 12:8 and the write select in bit 13 (1 = write, 0 = read). Bits 7:5 and 15:14 of a written command are ignored. The command readback returns the stored fields in the same positions, with bits 14 and 7:5 reading 0.
- R2: Bit 15 of the command readback is the finished flag. It is 1 whenever no frame is in flight. It reads 0 from the first cycle after a command write that is accepted while idle. It returns to 1 exactly 64 x MDC_DIV clock cycles after that write.
- R3: Each frame is 64 MDC periods, sent MSB first: 32 ones, start 01, opcode 10 (read) or 01 (write), 5-bit PHY address, 5-bit register number, turnaround (10 on a write), then 16 data bits.
- R4: MDC runs at the clock frequency divided by MDC_DIV, with its high phase lasting MDC_DIV/2 cycles. It stays low while idle. The MDIO output changes only together with a falling MDC edge. MDIO input is sampled at the rising MDC edge.
- R5: The output enable is high through the first 46 bits of every frame and through all of a write frame. It is low for the last 18 bits of a read frame and while idle. The idle output value is 1.
- R6: After a read frame, the data register holds the 16 bits the PHY drove, in the same cycle the finished flag returns to 1.
- R7: A write frame carries the data register value that was present at launch. A data register write while idle is read back unchanged.
- R8: Writes to the command register or the data register while a frame is in flight are ignored.
- R9: After reset, the data register reads 0, the command readback reads 0x8000, MDC is 0 and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = command word, 1 = data register |
| wr_data | input | 16 | Write value |
| ctrl_rdata | output | 16 | Command word readback with finished flag in bit 15 |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |
| mdio_i | input | 1 | Management data from the pad |

## Verification
The assertions assume that `mdio_i` is stable around each rising MDC edge. They also assume that the host honours the finished flag, so that register writes during a frame happen only as deliberate misuse. The bench's PHY model changes `mdio_i` only half a clock after a falling MDC edge, which keeps the input stable well before the next rise. The bench issues commands only after the flag has returned to 1. The one exception is a dedicated sequence that writes both registers mid-frame to show that such writes are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // field widths of the management frame
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_BITS    = 32;
  localparam int FRAME_BITS  = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  // bit index at which a read frame hands the line to the PHY
  localparam int RELEASE_IDX = PRE_BITS + 4 + 2 * ADDR_W;
  // first bit index carrying read data
  localparam int DATA_IDX    = RELEASE_IDX + 2;

  // positions inside the command word
  localparam int REG_LSB  = 0;
  localparam int PHY_LSB  = 8;
  localparam int WR_BIT   = 13;
  localparam int DONE_BIT = 15;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                        input logic [DATA_W-1:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] payload;
    op      = c.wr ? 2'b01 : 2'b10;
    ta      = c.wr ? 2'b10 : 2'b11;
    payload = c.wr ? wd : {DATA_W{1'b1}};
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int MDC_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = MDC_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = run && (cnt_q == CNT_END);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  mdc_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> mdc);
  // R4
  mdc_fall_chk: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              capture_stb,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [IDX_W-1:0] LAST_AT    = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] RELEASE_AT = IDX_W'(RELEASE_IDX);
  localparam logic [IDX_W-1:0] DATA_AT    = IDX_W'(DATA_IDX);

  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  is_wr_q;
  logic                  last_bit;
  logic [IDX_W-1:0]      idx_nx;

  assign last_bit    = (idx_q == LAST_AT);
  assign idx_nx      = idx_q + 1'b1;
  assign capture_stb = busy && !is_wr_q && fall_stb && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
      idx_q   <= '0;
      is_wr_q <= 1'b0;
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else if (!busy) begin
      if (load) begin
        frame_q <= build_frame(cmd, wdata);
        idx_q   <= '0;
        is_wr_q <= cmd.wr;
        busy    <= 1'b1;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_stb && !is_wr_q && (idx_q >= DATA_AT))
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (last_bit) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
          idx_q   <= '0;
        end else begin
          idx_q   <= idx_nx;
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
          mdio_o  <= frame_q[FRAME_BITS-2];
          mdio_oe <= is_wr_q || (idx_nx < RELEASE_AT);
        end
      end
    end
  end

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_wr_q && idx_q >= RELEASE_AT) |-> !mdio_oe);
  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && is_wr_q) |-> mdio_oe);
  // R3
  preamble_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mdio_o && mdio_oe));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int MDC_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t         cmd_q;
  mdio_cmd_t         cmd_new;
  logic [DATA_W-1:0] data_q;
  logic              busy;
  logic              rise_stb;
  logic              fall_stb;
  logic              capture_stb;
  logic [DATA_W-1:0] rx_data;
  logic              launch;
  logic              unused_bits;

  assign cmd_new.wr   = wr_data[WR_BIT];
  assign cmd_new.phy  = wr_data[PHY_LSB +: ADDR_W];
  assign cmd_new.regn = wr_data[REG_LSB +: ADDR_W];
  assign launch       = wr_en && !wr_sel && !busy;
  assign unused_bits  = ^{wr_data[15:14], wr_data[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (launch)
        cmd_q <= cmd_new;
      if (wr_en && wr_sel && !busy)
        data_q <= wr_data;
      else if (capture_stb)
        data_q <= rx_data;
    end
  end

  assign ctrl_rdata = {!busy, 1'b0, cmd_q.wr, cmd_q.phy, 3'b000, cmd_q.regn};
  assign data_rdata = data_q;

  mdio_clk_div #(.MDC_DIV(MDC_DIV)) div_i (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_shifter shf_i (
    .clk         (clk),
    .rst         (rst),
    .load        (launch),
    .cmd         (cmd_new),
    .wdata       (data_q),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .capture_stb (capture_stb),
    .rx_data     (rx_data)
  );

  // R4
  out_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));
  // R4
  idle_mdc_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[DONE_BIT] |-> !mdc);
  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && ctrl_rdata[DONE_BIT]) |=> !ctrl_rdata[DONE_BIT]);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_rdata[DONE_BIT] && wr_en && !capture_stb) |=>
      ($stable(data_rdata) && $stable(ctrl_rdata[13:0])));
endmodule

// File: tb/mdio_cmd_engine_tb_top.sv
module mdio_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_rdata;
  logic [15:0] data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdio_cmd_engine #(.MDC_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic [15:0] init_val(input logic [4:0] p, input logic [4:0] r);
    return ({11'b0, p} * 16'd1877) ^ ({11'b0, r} * 16'd263) ^ 16'hA55A;
  endfunction

  // ---------------- PHY model ----------------
  int          bidx = 0;
  int          hi_len = 0;
  int          oe_bad = 0;
  int          mdc_bad = 0;
  int          frames = 0;
  logic        mdc_q = 1'b0;
  logic [63:0] cap = '0;
  logic [63:0] last_frame = '0;
  logic [1:0]  p_op = 2'b00;
  logic [4:0]  p_phy = '0;
  logic [4:0]  p_reg = '0;
  logic [15:0] p_rd = '0;
  logic [15:0] wmem [1024];
  logic [1023:0] wvalid = '0;

  always @(negedge clk) begin
    if (rst) begin
      bidx = 0; mdc_q = 1'b0; hi_len = 0; mdio_i = 1'b1; wvalid = '0;
    end else begin
      if (mdc && !mdc_q) begin
        if (mdio_oe !== ((bidx < 46) || (p_op == 2'b01))) oe_bad++;
        cap = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
        bidx++;
        if (bidx == 36) p_op = cap[1:0];
        if (bidx == 46) begin
          p_phy = cap[9:5];
          p_reg = cap[4:0];
          p_rd  = wvalid[{p_phy, p_reg}] ? wmem[{p_phy, p_reg}] : init_val(p_phy, p_reg);
        end
        if (bidx == 64) begin
          frames++;
          last_frame = cap;
          if (p_op == 2'b01) begin
            wmem[{p_phy, p_reg}]   = cap[15:0];
            wvalid[{p_phy, p_reg}] = 1'b1;
          end
        end
        hi_len = 0;
      end
      if (mdc) hi_len++;
      if (!mdc && mdc_q) begin
        if (hi_len != DIV / 2) mdc_bad++;
        if (p_op == 2'b10 && bidx == 47) mdio_i = 1'b0;
        else if (p_op == 2'b10 && bidx >= 48 && bidx <= 63) mdio_i = p_rd[63 - bidx];
        else mdio_i = 1'b1;
      end
      if (ctrl_rdata[15]) begin
        bidx = 0; p_op = 2'b00; mdio_i = 1'b1;
      end
      mdc_q = mdc;
    end
  end

  // ---------------- bench expectations ----------------
  logic [15:0]   ewmem [1024];
  logic [1023:0] ewvalid = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(output int m);
    m = 0;
    while (!ctrl_rdata[15] && m < 100000) begin
      @(posedge clk); m++; @(negedge clk);
    end
  endtask

  task automatic run_cmd(input logic wr, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] wd, input bit junk);
    logic [15:0] cw;
    logic [15:0] exp_rd;
    logic [63:0] exp_fr;
    int m, oe0, mdc0, fr0;
    if (wr) begin
      bus_wr(1'b1, wd);
      // R7: data register readback while idle
      check(data_rdata == wd, "R7", 64'(data_rdata), 64'(wd));
    end
    oe0 = oe_bad; mdc0 = mdc_bad; fr0 = frames;
    cw = {junk ? 2'b11 : 2'b00, wr, p, junk ? 3'b111 : 3'b000, r};
    bus_wr(1'b0, cw);
    // R2: finished flag drops after launch
    check(ctrl_rdata[15] == 1'b0, "R2", 64'(ctrl_rdata[15]), 64'd0);
    wait_done(m);
    // R2: frame length in clock cycles
    check(m == 64 * DIV, "R2", 64'(m), 64'(64 * DIV));
    exp_fr = wr ? {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, wd}
                : {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'b0};
    // R3: frame content seen by the PHY
    check(frames == fr0 + 1 && last_frame == exp_fr, "R3", last_frame, exp_fr);
    // R5: output enable per bit
    check(oe_bad == oe0, "R5", 64'(oe_bad - oe0), 64'd0);
    // R4: MDC high phase length
    check(mdc_bad == mdc0, "R4", 64'(mdc_bad - mdc0), 64'd0);
    // R1: command readback fields
    check(ctrl_rdata == {1'b1, 1'b0, wr, p, 3'b000, r}, "R1", 64'(ctrl_rdata),
          64'({1'b1, 1'b0, wr, p, 3'b000, r}));
    // R5/R4: idle line state
    check(!mdc && !mdio_oe && mdio_o, "R5", 64'({mdc, mdio_oe, mdio_o}), 64'b001);
    if (wr) begin
      ewmem[{p, r}] = wd; ewvalid[{p, r}] = 1'b1;
      // R7: data register keeps the sent value
      check(data_rdata == wd, "R7", 64'(data_rdata), 64'(wd));
    end else begin
      exp_rd = ewvalid[{p, r}] ? ewmem[{p, r}] : init_val(p, r);
      // R6: read data lands in data register
      check(data_rdata == exp_rd, "R6", 64'(data_rdata), 64'(exp_rd));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int m, fr0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(ctrl_rdata == 16'h8000, "R9", 64'(ctrl_rdata), 64'h8000);
    check(data_rdata == 16'h0000, "R9", 64'(data_rdata), 64'h0);
    check(!mdc && !mdio_oe, "R9", 64'({mdc, mdio_oe}), 64'h0);

    // R6 R3: every register number of one PHY
    for (int r = 0; r < 32; r++) run_cmd(1'b0, 5'd5, 5'(r), 16'h0, 1'b0);
    // R6 R3: every PHY address at one register
    for (int p = 0; p < 32; p++) run_cmd(1'b0, 5'(p), 5'd17, 16'h0, 1'b0);
    // R7: writes across all addresses, then read back
    for (int p = 0; p < 32; p++)
      run_cmd(1'b1, 5'(p), 5'((p * 7) % 32), 16'((p * 16'h1111) ^ 16'h8421), 1'b0);
    for (int p = 0; p < 32; p++)
      run_cmd(1'b0, 5'(p), 5'((p * 7) % 32), 16'h0, 1'b0);
    // R1: unused command bits set
    run_cmd(1'b0, 5'd31, 5'd31, 16'h0, 1'b1);
    run_cmd(1'b1, 5'd10, 5'd3, 16'hFFFF, 1'b1);
    run_cmd(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0);

    // R8: writes during a frame are dropped
    bus_wr(1'b1, 16'hC3A5);
    fr0 = frames;
    bus_wr(1'b0, {2'b00, 1'b1, 5'd3, 3'b000, 5'd4});
    repeat (20) @(negedge clk);
    bus_wr(1'b0, {2'b00, 1'b0, 5'd9, 3'b000, 5'd9});
    bus_wr(1'b1, 16'h1234);
    wait_done(m);
    check(data_rdata == 16'hC3A5, "R8", 64'(data_rdata), 64'hC3A5);
    check(ctrl_rdata == {1'b1, 1'b0, 1'b1, 5'd3, 3'b000, 5'd4}, "R8",
          64'(ctrl_rdata), 64'({1'b1, 1'b0, 1'b1, 5'd3, 3'b000, 5'd4}));
    check(frames == fr0 + 1 && last_frame[15:0] == 16'hC3A5, "R8",
          64'(last_frame[15:0]), 64'hC3A5);
    repeat (4) @(negedge clk);
    check(frames == fr0 + 1, "R8", 64'(frames - fr0), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule